// File: doc/BRIEF.md
# Memory-Signal Timing Sequencer

This block produces the control waveforms for a single access to a pseudo-static RAM that shares one bus between address and data. A start pulse launches a per-access cycle counter in the fast internal clock domain. Every memory pin and every internal drive or sample point then switches at cycle numbers taken from a captured register set. The pins are chip select, address valid, output enable, write enable, the active-high bus drive enable and the address-drive window.

Burst beats are paced by an internal divider of 2, 3 or 4. The divider also shapes the external memory clock. That clock can be gated off, is held low in the asynchronous mode, and can optionally be launched half an internal cycle early for extra hold margin. A last-data marker lets the surrounding controller chain accesses. New timing values are taken only while a qualifier is high. Clearing the enable lets the access in flight finish and blocks further starts.

Top module: `psram_seq`

## Requirements
- R1: After reset every active-low pin (mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n) is high. bus_oe, addr_drive, mem_clk, wdat_stb, rdat_stb, last_data and busy are low.
- R2: A start sampled high on an edge while idle and enabled makes busy high from the next cycle, which is count 0. busy stays high through count E. E is rd_end for a read (is_read=1) and wr_end for a write. busy is low from count E+1. Whenever busy is low, every pin is inactive and no strobe or marker is high.
- R3: During count v each of mem_ce_n, mem_adv_n, mem_we_n and mem_oe_n is low, and bus_oe is high, exactly when on < v <= off for that signal's pair. When on equals off the signal never asserts, because the deassert compare wins.
- R4: addr_drive is high exactly when addr_on < v <= adv_off, so the address window closes together with address valid.
- R5: For writes, wdat_stb pulses at counts ws+1+k*D that are no greater than E. D is the effective divider and ws is wdat_on. rdat_stb does the same for reads with rdat_on. A write never raises rdat_stb, and a read never raises wdat_stb.
- R6: last_data is high only during count last_on+1, and only if that count is no greater than E.
- R7: The clock is allowed when clk_out_en is 1 and the mode latched at start is not 2'b01 (asynchronous). While busy and allowed, mem_clk is high when (v mod D) < D/2, using integer division. Otherwise mem_clk is low.
- R8: div_sel values 2, 3 and 4 give D directly. Values below 2 act as 2 and values above 4 act as 4.
- R9: Timing values, div_sel, clk_out_en and clk_early are captured only on edges where cfg_valid is high. Values presented while cfg_valid is low have no effect on later accesses.
- R10: While enable is low, a start is ignored and busy stays low. An access already running completes with unchanged timing.
- R11: A start pulse during a running access is ignored, and the count continues undisturbed.
- R12: With clk_early set, mem_clk changes on the falling internal edge and shows, half an internal cycle ahead, the level it would otherwise show in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permits new accesses |
| start | input | 1 | Launch pulse for one access |
| is_read | input | 1 | 1 = read, 0 = write, sampled at start |
| mode | input | 2 | Access mode, sampled at start; 2'b01 = asynchronous |
| cfg_valid | input | 1 | Capture qualifier for the timing set |
| ce_on | input | 5 | Chip-select assert cycle |
| ce_off | input | 5 | Chip-select deassert cycle |
| adv_on | input | 5 | Address-valid assert cycle |
| adv_off | input | 5 | Address-valid deassert cycle, also ends the address window |
| we_on | input | 5 | Write-enable assert cycle |
| we_off | input | 5 | Write-enable deassert cycle |
| oe_on | input | 5 | Output-enable assert cycle |
| oe_off | input | 5 | Output-enable deassert cycle |
| bus_on | input | 5 | Bus drive enable assert cycle |
| bus_off | input | 5 | Bus drive enable deassert cycle |
| addr_on | input | 5 | Cycle the address goes onto the bus |
| wdat_on | input | 5 | First write-beat cycle |
| rdat_on | input | 5 | First read-sample cycle |
| last_on | input | 5 | Last-data marker cycle |
| rd_end | input | 5 | Final count of a read |
| wr_end | input | 5 | Final count of a write |
| div_sel | input | 3 | Internal-to-external clock ratio |
| clk_out_en | input | 1 | Permits driving the memory clock |
| clk_early | input | 1 | Launches the memory clock half a cycle early |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| bus_oe | output | 1 | Shared bus drive enable, active high |
| addr_drive | output | 1 | Address placed on the shared bus |
| mem_clk | output | 1 | Divided memory clock |
| wdat_stb | output | 1 | Write beat drive strobe |
| rdat_stb | output | 1 | Read beat sample strobe |
| last_data | output | 1 | Last-data-cycle marker |
| busy | output | 1 | Access in progress |

## Verification
An event programmed at cycle c is due one register later, during count c+1. Count 0 is the first cycle after the edge that samples start. The bench starts each access 5 ns after an edge and walks the count in step with the design. For every count it compares the registered pins, strobes and marker with a model of these rules, all sampled 5 ns after the edge. It reads mem_clk a second time 15 ns after the edge, after the falling edge. There, the early-launch setting must already show the next count's level, while the normal setting must still show the current one.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int TW   = 5;   // timing field width
    localparam int DW   = 3;   // divider field width
    localparam int NPIN = 6;   // windowed outputs

    localparam int PIN_CE   = 0;
    localparam int PIN_ADV  = 1;
    localparam int PIN_WE   = 2;
    localparam int PIN_OE   = 3;
    localparam int PIN_BUS  = 4;
    localparam int PIN_ADDR = 5;

    typedef logic [TW-1:0] tcyc_t;
    typedef logic [DW-1:0] div_t;

    typedef enum logic [1:0] {
        MODE_SYNC   = 2'b00,
        MODE_ASYNC  = 2'b01,
        MODE_CFG_SW = 2'b10,
        MODE_CFG_RG = 2'b11
    } mode_e;

    typedef struct packed {
        tcyc_t on;
        tcyc_t off;
    } window_t;

    typedef struct packed {
        window_t [NPIN-1:0] win;
        tcyc_t              wdat_on;
        tcyc_t              rdat_on;
        tcyc_t              last_on;
        tcyc_t              rd_end;
        tcyc_t              wr_end;
        div_t               div;
        logic               clk_en;
        logic               clk_early;
    } tcfg_t;

    localparam div_t DIV_MIN = DW'(2);
    localparam div_t DIV_MAX = DW'(4);

    localparam tcfg_t CFG_RST = '{
        win: '0, wdat_on: '0, rdat_on: '0, last_on: '0,
        rd_end: '0, wr_end: '0, div: DIV_MIN,
        clk_en: 1'b0, clk_early: 1'b0
    };

    function automatic div_t clamp_div(input div_t d);
        if (d < DIV_MIN) return DIV_MIN;
        if (d > DIV_MAX) return DIV_MAX;
        return d;
    endfunction

endpackage

// File: rtl/psq_window.sv
module psq_window
    import psq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  logic    at_end,
    input  tcyc_t   cnt,
    input  window_t win,
    output logic    active
);

    always_ff @(posedge clk) begin
        if (rst || !busy || at_end) begin
            active <= 1'b0;
        end else if (cnt == win.off) begin
            active <= 1'b0;          // deassert has priority
        end else if (cnt == win.on) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/psq_beat.sv
module psq_beat
    import psq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  at_end,
    input  logic  allow,
    input  tcyc_t cnt,
    input  tcyc_t first,
    input  div_t  div,
    output logic  stb
);

    logic run_q;
    div_t ph_q;

    always_ff @(posedge clk) begin
        if (rst || !busy || at_end) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            stb   <= 1'b0;
        end else if (allow && cnt == first) begin
            run_q <= 1'b1;
            ph_q  <= DW'(1);
            stb   <= 1'b1;
        end else if (run_q && ph_q >= div) begin
            ph_q  <= DW'(1);
            stb   <= 1'b1;
        end else begin
            stb <= 1'b0;
            if (run_q) ph_q <= ph_q + 1'b1;
        end
    end

    // R5
    beat_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && div >= DW'(2) && $stable(div)) |=> !stb);

endmodule

// File: rtl/psq_clkgen.sv
module psq_clkgen
    import psq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_go,
    input  logic run_nxt,
    input  logic clk_ok,
    input  div_t div,
    input  logic early,
    output logic mem_clk
);

    div_t ph_q, ph_nxt;
    logic lvl_nxt;
    logic pos_q, neg_q;

    always_comb begin
        if (start_go || ph_q >= div - 1'b1) ph_nxt = '0;
        else                                ph_nxt = ph_q + 1'b1;
        lvl_nxt = run_nxt && clk_ok && (ph_nxt < (div >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            pos_q <= 1'b0;
        end else begin
            ph_q  <= ph_nxt;
            pos_q <= lvl_nxt;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= lvl_nxt;
    end

    assign mem_clk = early ? neg_q : pos_q;

    // R7
    clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_nxt |=> !pos_q);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       start,
    input  logic       is_read,
    input  logic [1:0] mode,
    input  logic       cfg_valid,
    input  logic [4:0] ce_on,
    input  logic [4:0] ce_off,
    input  logic [4:0] adv_on,
    input  logic [4:0] adv_off,
    input  logic [4:0] we_on,
    input  logic [4:0] we_off,
    input  logic [4:0] oe_on,
    input  logic [4:0] oe_off,
    input  logic [4:0] bus_on,
    input  logic [4:0] bus_off,
    input  logic [4:0] addr_on,
    input  logic [4:0] wdat_on,
    input  logic [4:0] rdat_on,
    input  logic [4:0] last_on,
    input  logic [4:0] rd_end,
    input  logic [4:0] wr_end,
    input  logic [2:0] div_sel,
    input  logic       clk_out_en,
    input  logic       clk_early,
    output logic       mem_ce_n,
    output logic       mem_adv_n,
    output logic       mem_we_n,
    output logic       mem_oe_n,
    output logic       bus_oe,
    output logic       addr_drive,
    output logic       mem_clk,
    output logic       wdat_stb,
    output logic       rdat_stb,
    output logic       last_data,
    output logic       busy
);

    tcfg_t cfg_in, cfg_q;
    logic  busy_q, rd_q, last_q;
    tcyc_t cnt_q, end_cyc;
    mode_e mode_q;
    logic  start_go, at_end, run_nxt, clk_ok_nxt;
    logic [NPIN-1:0] pin_act;

    // ---- timing register set ----
    always_comb begin
        cfg_in.win[PIN_CE]   = '{on: ce_on,   off: ce_off};
        cfg_in.win[PIN_ADV]  = '{on: adv_on,  off: adv_off};
        cfg_in.win[PIN_WE]   = '{on: we_on,   off: we_off};
        cfg_in.win[PIN_OE]   = '{on: oe_on,   off: oe_off};
        cfg_in.win[PIN_BUS]  = '{on: bus_on,  off: bus_off};
        cfg_in.win[PIN_ADDR] = '{on: addr_on, off: adv_off};
        cfg_in.wdat_on   = wdat_on;
        cfg_in.rdat_on   = rdat_on;
        cfg_in.last_on   = last_on;
        cfg_in.rd_end    = rd_end;
        cfg_in.wr_end    = wr_end;
        cfg_in.div       = clamp_div(div_sel);
        cfg_in.clk_en    = clk_out_en;
        cfg_in.clk_early = clk_early;
    end

    always_ff @(posedge clk) begin
        if (rst)            cfg_q <= CFG_RST;
        else if (cfg_valid) cfg_q <= cfg_in;
    end

    // ---- access counter ----
    assign start_go = start && enable && !busy_q;
    assign end_cyc  = rd_q ? cfg_q.rd_end : cfg_q.wr_end;
    assign at_end   = busy_q && (cnt_q == end_cyc);
    assign run_nxt  = start_go || (busy_q && !at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            mode_q <= MODE_SYNC;
        end else if (start_go) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rd_q   <= is_read;
            mode_q <= mode_e'(mode);
        end else if (at_end) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // ---- windowed pins ----
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        psq_window u_win (
            .clk    (clk),
            .rst    (rst),
            .busy   (busy_q),
            .at_end (at_end),
            .cnt    (cnt_q),
            .win    (cfg_q.win[g]),
            .active (pin_act[g])
        );
    end

    // ---- data beat strobes ----
    psq_beat u_wbeat (
        .clk(clk), .rst(rst), .busy(busy_q), .at_end(at_end),
        .allow(!rd_q), .cnt(cnt_q), .first(cfg_q.wdat_on),
        .div(cfg_q.div), .stb(wdat_stb)
    );

    psq_beat u_rbeat (
        .clk(clk), .rst(rst), .busy(busy_q), .at_end(at_end),
        .allow(rd_q), .cnt(cnt_q), .first(cfg_q.rdat_on),
        .div(cfg_q.div), .stb(rdat_stb)
    );

    // ---- last-data marker ----
    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= busy_q && !at_end && (cnt_q == cfg_q.last_on);
    end

    // ---- memory clock ----
    assign clk_ok_nxt = cfg_q.clk_en &&
                        ((start_go ? mode_e'(mode) : mode_q) != MODE_ASYNC);

    psq_clkgen u_clk (
        .clk      (clk),
        .rst      (rst),
        .start_go (start_go),
        .run_nxt  (run_nxt),
        .clk_ok   (clk_ok_nxt),
        .div      (cfg_q.div),
        .early    (cfg_q.clk_early),
        .mem_clk  (mem_clk)
    );

    assign mem_ce_n   = !pin_act[PIN_CE];
    assign mem_adv_n  = !pin_act[PIN_ADV];
    assign mem_we_n   = !pin_act[PIN_WE];
    assign mem_oe_n   = !pin_act[PIN_OE];
    assign bus_oe     =  pin_act[PIN_BUS];
    assign addr_drive =  pin_act[PIN_ADDR];
    assign last_data  =  last_q;
    assign busy       =  busy_q;

    // ---- checks ----
    // R2
    pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n &&
                     !bus_oe && !addr_drive && !wdat_stb && !rdat_stb && !last_data));

    // R2
    end_stop_chk: assert property (@(posedge clk) disable iff (rst)
        at_end |=> !busy_q);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !at_end && start) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

    // R10
    no_start_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !enable) |=> !busy_q);

    // R7
    async_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && mode_q == MODE_ASYNC && !cfg_q.clk_early) |-> !mem_clk);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wdat_stb, rdat_stb}));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> $stable(cfg_q));

    // R8
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.div >= DIV_MIN && cfg_q.div <= DIV_MAX);

endmodule

// File: tb/test_psram_seq.sv
module test_psram_seq;

    typedef struct packed {
        bit       rd;
        bit [1:0] mode;
        bit [2:0] div_sel;
        bit       clk_en;
        bit       early;
        bit [4:0] ce_on, ce_off, adv_on, adv_off, we_on, we_off;
        bit [4:0] oe_on, oe_off, bus_on, bus_off, addr_on;
        bit [4:0] ws, rs, last, rd_end, wr_end;
        bit [5:0] beats;   // expected strobe count
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'b00, 3'd2, 1'b1, 1'b0, 5'd0, 5'd20, 5'd1, 5'd5, 5'd2, 5'd18,
          5'd31, 5'd31, 5'd3, 5'd18, 5'd0, 5'd6, 5'd0, 5'd16, 5'd12, 5'd21, 6'd8},
        '{1'b1, 2'b00, 3'd3, 1'b1, 1'b0, 5'd0, 5'd22, 5'd1, 5'd4, 5'd30, 5'd30,
          5'd8, 5'd21, 5'd0, 5'd3, 5'd0, 5'd5, 5'd9, 5'd19, 5'd23, 5'd10, 6'd5},
        '{1'b1, 2'b01, 3'd4, 1'b1, 1'b0, 5'd1, 5'd15, 5'd2, 5'd6, 5'd3, 5'd3,
          5'd7, 5'd14, 5'd1, 5'd5, 5'd1, 5'd0, 5'd10, 5'd12, 5'd16, 5'd9, 6'd2},
        '{1'b0, 2'b00, 3'd4, 1'b1, 1'b0, 5'd0, 5'd27, 5'd0, 5'd7, 5'd4, 5'd25,
          5'd20, 5'd20, 5'd2, 5'd26, 5'd0, 5'd9, 5'd3, 5'd24, 5'd5, 5'd28, 6'd5},
        '{1'b0, 2'b10, 3'd3, 1'b0, 1'b0, 5'd2, 5'd9, 5'd3, 5'd4, 5'd5, 5'd8,
          5'd0, 5'd0, 5'd3, 5'd9, 5'd2, 5'd4, 5'd1, 5'd8, 5'd2, 5'd11, 6'd3},
        '{1'b1, 2'b00, 3'd2, 1'b1, 1'b1, 5'd0, 5'd31, 5'd0, 5'd2, 5'd0, 5'd0,
          5'd4, 5'd31, 5'd0, 5'd1, 5'd0, 5'd0, 5'd0, 5'd30, 5'd31, 5'd3, 6'd16}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic enable = 1'b0, start = 1'b0, is_read = 1'b0, cfg_valid = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [4:0] ce_on, ce_off, adv_on, adv_off, we_on, we_off, oe_on, oe_off;
    logic [4:0] bus_on, bus_off, addr_on, wdat_on, rdat_on, last_on, rd_end, wr_end;
    logic [2:0] div_sel;
    logic clk_out_en, clk_early;
    logic mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, bus_oe, addr_drive, mem_clk;
    logic wdat_stb, rdat_stb, last_data, busy;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    psram_seq i_psram_seq (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .is_read(is_read),
        .mode(mode), .cfg_valid(cfg_valid),
        .ce_on(ce_on), .ce_off(ce_off), .adv_on(adv_on), .adv_off(adv_off),
        .we_on(we_on), .we_off(we_off), .oe_on(oe_on), .oe_off(oe_off),
        .bus_on(bus_on), .bus_off(bus_off), .addr_on(addr_on),
        .wdat_on(wdat_on), .rdat_on(rdat_on), .last_on(last_on),
        .rd_end(rd_end), .wr_end(wr_end), .div_sel(div_sel),
        .clk_out_en(clk_out_en), .clk_early(clk_early),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .bus_oe(bus_oe), .addr_drive(addr_drive),
        .mem_clk(mem_clk), .wdat_stb(wdat_stb), .rdat_stb(rdat_stb),
        .last_data(last_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---- model of the requirements ----
    function automatic bit in_win(input int on, input int off, input int v);
        return (on < v) && (v <= off);
    endfunction

    function automatic int eff_div(input int d);
        if (d < 2) return 2;
        if (d > 4) return 4;
        return d;
    endfunction

    function automatic bit beat_at(input int first, input int d, input int v);
        return (v >= first + 1) && (((v - first - 1) % d) == 0);
    endfunction

    function automatic bit clk_lvl(input vec_t m, input int v);
        int d;
        d = eff_div(int'(m.div_sel));
        if (v > int'(m.rd ? m.rd_end : m.wr_end)) return 1'b0;
        if (!m.clk_en || m.mode == 2'b01) return 1'b0;
        return (v % d) < (d / 2);
    endfunction

    task automatic apply_cfg(input vec_t m, input bit valid);
        ce_on = m.ce_on;   ce_off = m.ce_off;   adv_on = m.adv_on; adv_off = m.adv_off;
        we_on = m.we_on;   we_off = m.we_off;   oe_on = m.oe_on;   oe_off = m.oe_off;
        bus_on = m.bus_on; bus_off = m.bus_off; addr_on = m.addr_on;
        wdat_on = m.ws;    rdat_on = m.rs;      last_on = m.last;
        rd_end = m.rd_end; wr_end = m.wr_end;   div_sel = m.div_sel;
        clk_out_en = m.clk_en; clk_early = m.early;
        cfg_valid = valid;
        @(posedge clk); #5;
    endtask

    // Enters and leaves 5 ns after a rising edge.
    task automatic run_access(input vec_t m, input int drop_at, input int restart_at);
        int endc, d, nbeat;
        bit exp15;
        endc  = int'(m.rd ? m.rd_end : m.wr_end);
        d     = eff_div(int'(m.div_sel));
        nbeat = 0;
        is_read = m.rd; mode = m.mode; start = 1'b1;
        @(posedge clk); #5;
        start = 1'b0;
        for (int v = 0; v <= endc; v++) begin
            chk(busy == 1'b1, "R2", "busy during access", busy, 1);
            chk(mem_ce_n  == !in_win(m.ce_on,  m.ce_off,  v), "R3", "mem_ce_n",  mem_ce_n,  !in_win(m.ce_on,  m.ce_off,  v));
            chk(mem_adv_n == !in_win(m.adv_on, m.adv_off, v), "R3", "mem_adv_n", mem_adv_n, !in_win(m.adv_on, m.adv_off, v));
            chk(mem_we_n  == !in_win(m.we_on,  m.we_off,  v), "R3", "mem_we_n",  mem_we_n,  !in_win(m.we_on,  m.we_off,  v));
            chk(mem_oe_n  == !in_win(m.oe_on,  m.oe_off,  v), "R3", "mem_oe_n",  mem_oe_n,  !in_win(m.oe_on,  m.oe_off,  v));
            chk(bus_oe    ==  in_win(m.bus_on, m.bus_off, v), "R3", "bus_oe",    bus_oe,     in_win(m.bus_on, m.bus_off, v));
            chk(addr_drive == in_win(m.addr_on, m.adv_off, v), "R4", "addr_drive", addr_drive, in_win(m.addr_on, m.adv_off, v));
            chk(wdat_stb == (!m.rd && beat_at(m.ws, d, v)), "R5", "wdat_stb", wdat_stb, !m.rd && beat_at(m.ws, d, v));
            chk(rdat_stb == ( m.rd && beat_at(m.rs, d, v)), "R5", "rdat_stb", rdat_stb,  m.rd && beat_at(m.rs, d, v));
            chk(last_data == (v == int'(m.last) + 1), "R6", "last_data", last_data, v == int'(m.last) + 1);
            chk(mem_clk == clk_lvl(m, v), "R7", "mem_clk at +5ns", mem_clk, clk_lvl(m, v));
            nbeat += int'(wdat_stb) + int'(rdat_stb);
            if (v == drop_at) enable = 1'b0;
            start = (v == restart_at);
            #10;
            exp15 = m.early ? ((v == endc) ? 1'b0 : clk_lvl(m, v + 1)) : clk_lvl(m, v);
            chk(mem_clk == exp15, "R12", "mem_clk after falling edge", mem_clk, exp15);
            @(posedge clk); #5;
        end
        start = 1'b0;
        chk(nbeat == int'(m.beats), "R5", "beat count", nbeat, int'(m.beats));
        chk(busy == 1'b0, "R2", "busy after end", busy, 0);
        chk(mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n && !bus_oe && !addr_drive,
            "R2", "pins idle after end", {mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, bus_oe, addr_drive}, 6'b111100);
        chk(mem_clk == 1'b0, "R7", "mem_clk idle", mem_clk, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t m;
        apply_cfg(VT[0], 1'b0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;

        // R1 reset state
        chk(mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n, "R1", "active-low pins high",
            {mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n}, 4'hf);
        chk(!bus_oe && !addr_drive && !mem_clk, "R1", "bus/addr/clk low",
            {bus_oe, addr_drive, mem_clk}, 0);
        chk(!wdat_stb && !rdat_stb && !last_data && !busy, "R1", "strobes/busy low",
            {wdat_stb, rdat_stb, last_data, busy}, 0);

        enable = 1'b1;

        // table walk: R2..R7, R12
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VT[i], 1'b1);
            run_access(VT[i], -1, -1);
        end

        // R8 divider clamp: 7 acts as 4, 0 acts as 2
        m = VT[3]; m.div_sel = 3'd7;
        apply_cfg(m, 1'b1);
        run_access(m, -1, -1);
        m = VT[0]; m.div_sel = 3'd0;
        apply_cfg(m, 1'b1);
        run_access(m, -1, -1);

        // R9 values presented while cfg_valid is low are ignored
        apply_cfg(VT[1], 1'b1);
        apply_cfg(VT[3], 1'b0);
        run_access(VT[1], -1, -1);
        cfg_valid = 1'b1;

        // R10 enable drops mid-access: access completes, later start ignored
        apply_cfg(VT[4], 1'b1);
        run_access(VT[4], 3, -1);
        start = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #5;
            chk(busy == 1'b0 && mem_ce_n == 1'b1, "R10", "start while disabled",
                {busy, mem_ce_n}, 2'b01);
        end
        start  = 1'b0;
        enable = 1'b1;

        // R11 start during access ignored
        apply_cfg(VT[1], 1'b1);
        run_access(VT[1], -1, 5);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule